// File: doc/BRIEF.md
# Timer interrupt status unit

This block is the interrupt side of a two-timer peripheral. Each timer delivers a one-cycle expiry pulse. The pulse sets that timer's bit in a sticky status register, and the bit holds until software acknowledges it. A software mask gates the status bits. When any gated bit is pending, a single registered interrupt line to the interrupt controller goes high.

Software reaches the unit through a simple word bus. The bus has a write strobe, an address, write data and combinational read data. Through this bus software can:
- write and read the mask;
- clear status bits by writing ones to an acknowledge location;
- read the raw status and the masked status;
- program one control word per timer.

A three-bit clock-source field in each control word is decoded into a clock choice for that timer. A watchdog control location is accepted on the bus but does nothing.

The interrupt line comes from a two-state machine. `IRQ_QUIET` means the line is low and `IRQ_RAISED` means it is high. The transition `T_RAISE` (QUIET to RAISED) fires when the next masked-pending vector is non-zero. The transition `T_DROP` (RAISED to QUIET) fires when that vector becomes zero. Every other case holds the state.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset the mask, the status, both control words and the interrupt line are zero, and both clock-source outputs read 0 (off).
- R2: An expiry pulse on `expire_i[i]` sets status bit i: timer 0 owns bit 0 and timer 1 owns bit 1. The bit stays set until it is acknowledged. Raw status is read at offset 0x50, with the upper bits zero.
- R3: A write to offset 0x48 stores the mask (bit i gates timer i), and the mask reads back at 0x48. On the clock edge of that write, the interrupt line is re-evaluated against the new mask.
- R4: An expiry whose bit is enabled in the mask raises `irq_o` one clock after the pulse. An expiry whose bit is masked leaves `irq_o` low.
- R5: A write to offset 0x4C clears every status bit whose write-data bit is 1, and leaves the other status bits unchanged.
- R6: After an acknowledge, `irq_o` falls only when status AND mask is zero; otherwise it stays high.
- R7: A read at offset 0x54 returns status AND mask.
- R8: When an expiry and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R9: The control word of timer i sits at offset 0x08 + 0x10*i and reads back in full. Its bits [2:0] select the clock. `clk_src_o[2i+1:2i]` decodes that field as follows: codes 0 and 1 give 0 (external or disabled), code 4 gives 1 (29.493 MHz reference), code 5 gives 2 (32 MHz reference), and any other code gives 3 (reserved).
- R10: A write to the watchdog location at offset 0x40 changes no register, no clock-source output and not the interrupt line. A read there returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| expire_i | input | NUM_TIMERS | One-cycle expiry pulse per timer |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request to the controller |
| clk_src_o | output | 2*NUM_TIMERS | Decoded clock choice, two bits per timer |

## Verification
The bench builds the unit with its defaults: two timers, a 32-bit data word and 8-bit offsets. With only two status bits, it can walk every combination of mask value, expiry pattern and acknowledge pattern (64 cases). For each case it computes the raw status, the masked status and the interrupt level arithmetically. It also sweeps all eight clock-source codes on each timer, checking the decoded output and that the other timer's output is untouched. Directed cases cover a set and a clear of the same bit in the same cycle, and the ignored watchdog write.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

    // Register byte offsets (fixed by software that drives the unit)
    localparam int OFS_WDOG   = 'h40;
    localparam int OFS_MASK   = 'h48;
    localparam int OFS_ACK    = 'h4C;
    localparam int OFS_RAW    = 'h50;
    localparam int OFS_MASKED = 'h54;

    // Clock-source field codes
    localparam int CKCODE_EXT  = 0;
    localparam int CKCODE_DIS  = 1;
    localparam int CKCODE_REFA = 4;
    localparam int CKCODE_REFB = 5;

    typedef enum logic [1:0] {
        CKSRC_OFF  = 2'd0,
        CKSRC_REFA = 2'd1,
        CKSRC_REFB = 2'd2,
        CKSRC_RSVD = 2'd3
    } cksrc_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/tmr_irq_bus_dec.sv
module tmr_irq_bus_dec
    import tmr_irq_pkg::*;
#(
    parameter int NUM_TIMERS  = 2,
    parameter int ADDR_W      = 8,
    parameter int CTRL_BASE   = 'h08,
    parameter int CTRL_STRIDE = 'h10
) (
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic                  wr_mask_o,
    output logic                  wr_ack_o,
    output logic [NUM_TIMERS-1:0] wr_ctrl_o
);

    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);

    always_comb begin
        wr_mask_o = wr_i && (addr_i == A_MASK);
        wr_ack_o  = wr_i && (addr_i == A_ACK);
    end

    for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_ctrl_dec
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_BASE + gi * CTRL_STRIDE);
        assign wr_ctrl_o[gi] = wr_i && (addr_i == A_CTRL);
    end

endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status #(
    parameter int NUM_TIMERS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_TIMERS-1:0] expire_i,
    input  logic                  wr_mask_i,
    input  logic                  wr_ack_i,
    input  logic [NUM_TIMERS-1:0] wbits_i,
    output logic [NUM_TIMERS-1:0] status_q_o,
    output logic [NUM_TIMERS-1:0] mask_q_o,
    output logic                  pend_next_o
);

    logic [NUM_TIMERS-1:0] status_q, status_d;
    logic [NUM_TIMERS-1:0] mask_q, mask_d;
    logic [NUM_TIMERS-1:0] clr_bits;

    always_comb begin
        clr_bits = wr_ack_i ? wbits_i : '0;
        // a new expiry wins over a clear of the same bit
        status_d = (status_q & ~clr_bits) | expire_i;
        mask_d   = wr_mask_i ? wbits_i : mask_q;
        pend_next_o = |(status_d & mask_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
        end
    end

    assign status_q_o = status_q;
    assign mask_q_o   = mask_q;

endmodule

// File: rtl/tmr_irq_fsm.sv
module tmr_irq_fsm
    import tmr_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_next_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    // next state: T_RAISE and T_DROP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_next_i)  state_d = IRQ_RAISED; // T_RAISE
            IRQ_RAISED: if (!pend_next_i) state_d = IRQ_QUIET;  // T_DROP
            default:                      state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_irq_cksel.sv
module tmr_irq_cksel
    import tmr_irq_pkg::*;
#(
    parameter int CKSEL_W = 3
) (
    input  logic [CKSEL_W-1:0] code_i,
    output cksrc_e             src_o
);

    always_comb begin
        unique case (code_i)
            CKSEL_W'(CKCODE_EXT),
            CKSEL_W'(CKCODE_DIS):  src_o = CKSRC_OFF;
            CKSEL_W'(CKCODE_REFA): src_o = CKSRC_REFA;
            CKSEL_W'(CKCODE_REFB): src_o = CKSRC_REFB;
            default:               src_o = CKSRC_RSVD;
        endcase
    end

endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
    import tmr_irq_pkg::*;
#(
    parameter int NUM_TIMERS  = 2,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int CTRL_BASE   = 'h08,
    parameter int CTRL_STRIDE = 'h10,
    parameter int CKSEL_LSB   = 0,
    parameter int CKSEL_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_TIMERS-1:0]   expire_i,
    input  logic                    bus_wr_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic [DATA_W-1:0]       bus_wdata_i,
    output logic [DATA_W-1:0]       bus_rdata_o,
    output logic                    irq_o,
    output logic [2*NUM_TIMERS-1:0] clk_src_o
);

    localparam int PAD_W = DATA_W - NUM_TIMERS;

    logic                  wr_mask, wr_ack;
    logic [NUM_TIMERS-1:0] wr_ctrl;
    logic [NUM_TIMERS-1:0] status_q, mask_q;
    logic                  pend_next;
    logic [DATA_W-1:0]     ctrl_q [NUM_TIMERS];

    tmr_irq_bus_dec #(
        .NUM_TIMERS (NUM_TIMERS),
        .ADDR_W     (ADDR_W),
        .CTRL_BASE  (CTRL_BASE),
        .CTRL_STRIDE(CTRL_STRIDE)
    ) u_dec (
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .wr_mask_o (wr_mask),
        .wr_ack_o  (wr_ack),
        .wr_ctrl_o (wr_ctrl)
    );

    tmr_irq_status #(.NUM_TIMERS(NUM_TIMERS)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire_i),
        .wr_mask_i  (wr_mask),
        .wr_ack_i   (wr_ack),
        .wbits_i    (bus_wdata_i[NUM_TIMERS-1:0]),
        .status_q_o (status_q),
        .mask_q_o   (mask_q),
        .pend_next_o(pend_next)
    );

    tmr_irq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_next_i(pend_next),
        .irq_o      (irq_o)
    );

    for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_tmr
        cksrc_e src;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           ctrl_q[gi] <= '0;
            else if (wr_ctrl[gi]) ctrl_q[gi] <= bus_wdata_i;
        end

        tmr_irq_cksel #(.CKSEL_W(CKSEL_W)) u_ck (
            .code_i(ctrl_q[gi][CKSEL_LSB +: CKSEL_W]),
            .src_o (src)
        );

        assign clk_src_o[2*gi +: 2] = src;
    end

    // read mux; watchdog and unmapped offsets read zero
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(OFS_MASK))
            bus_rdata_o = {{PAD_W{1'b0}}, mask_q};
        else if (bus_addr_i == ADDR_W'(OFS_RAW))
            bus_rdata_o = {{PAD_W{1'b0}}, status_q};
        else if (bus_addr_i == ADDR_W'(OFS_MASKED))
            bus_rdata_o = {{PAD_W{1'b0}}, status_q & mask_q};
        for (int i = 0; i < NUM_TIMERS; i++)
            if (bus_addr_i == ADDR_W'(CTRL_BASE + i * CTRL_STRIDE))
                bus_rdata_o = ctrl_q[i];
    end

endmodule

// File: rtl/tmr_irq_unit_chk.sv
module tmr_irq_unit_chk
    import tmr_irq_pkg::*;
#(
    parameter int NUM_TIMERS = 2,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_TIMERS-1:0]   expire_i,
    input logic                    bus_wr_i,
    input logic [ADDR_W-1:0]       bus_addr_i,
    input logic [DATA_W-1:0]       bus_wdata_i,
    input logic                    irq_o,
    input logic [2*NUM_TIMERS-1:0] clk_src_o,
    input logic [NUM_TIMERS-1:0]   status_q,
    input logic [NUM_TIMERS-1:0]   mask_q
);

    logic wr_mask_c, wr_ack_c, wr_wd_c;
    assign wr_mask_c = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_MASK));
    assign wr_ack_c  = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_ACK));
    assign wr_wd_c   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_WDOG));

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire_i) |=> ((status_q & $past(expire_i)) == $past(expire_i)));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ack_c) |=> ((status_q & $past(status_q)) == $past(status_q)));

    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(expire_i & mask_q)) && !wr_mask_c) |=> irq_o);

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ack_c && expire_i == '0) |=>
            ((status_q & $past(bus_wdata_i[NUM_TIMERS-1:0])) == '0));

    p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (irq_o == (|(status_q & mask_q))));

    p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_c |=> (mask_q == $past(bus_wdata_i[NUM_TIMERS-1:0])));

    p_wdog_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_wd_c && expire_i == '0) |=>
            ($stable(status_q) && $stable(mask_q) && $stable(irq_o) && $stable(clk_src_o)));

endmodule

bind tmr_irq_unit tmr_irq_unit_chk #(
    .NUM_TIMERS(NUM_TIMERS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_i   (expire_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .irq_o      (irq_o),
    .clk_src_o  (clk_src_o),
    .status_q   (status_q),
    .mask_q     (mask_q)
);

// File: tb/sim_tmr_irq_unit.sv
module sim_tmr_irq_unit;

    localparam int NT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  expire = '0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [3:0]  clk_src;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    tmr_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .expire_i(expire),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .clk_src_o(clk_src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] ex);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; expire = ex;
        @(negedge clk);
        wr = 1'b0; expire = '0;
    endtask

    task automatic pulse(input logic [1:0] ex);
        @(negedge clk);
        expire = ex;
        @(negedge clk);
        expire = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic [1:0] exp_src(input int code);
        if (code == 0 || code == 1) return 2'd0;
        if (code == 4) return 2'd1;
        if (code == 5) return 2'd2;
        return 2'd3;
    endfunction

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'h48, d); chk("R1 mask", d, 0);
        bus_read(8'h50, d); chk("R1 raw", d, 0);
        bus_read(8'h54, d); chk("R1 masked", d, 0);
        bus_read(8'h08, d); chk("R1 ctrl0", d, 0);
        bus_read(8'h18, d); chk("R1 ctrl1", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 clksrc", {28'b0, clk_src}, 0);

        // sweep mask x expiry pattern x acknowledge pattern
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int a = 0; a < 4; a++) begin
                    logic [1:0] left;
                    bus_write(8'h4C, 32'hFFFF_FFFF, 2'b00);
                    bus_write(8'h48, 32'(m), 2'b00);
                    bus_read(8'h48, d); chk("R3 mask readback", d, 32'(m));
                    pulse(2'(s));
                    #1;
                    chk("R4 irq after expiry", {31'b0, irq}, {31'b0, |(2'(s) & 2'(m))});
                    bus_read(8'h50, d); chk("R2 raw after expiry", d, 32'(s));
                    bus_read(8'h54, d); chk("R7 masked", d, 32'(s & m));
                    bus_write(8'h4C, 32'(a) | 32'hFFFF_FFF0 & 32'h0, 2'b00);
                    left = 2'(s & ~a);
                    #1;
                    chk("R6 irq after ack", {31'b0, irq}, {31'b0, |(left & 2'(m))});
                    bus_read(8'h50, d); chk("R5 raw after ack", d, 32'(left));
                    bus_write(8'h48, 32'h3, 2'b00);
                    #1;
                    chk("R3 irq after mask write", {31'b0, irq}, {31'b0, |left});
                end
            end
        end

        // R8 expiry and acknowledge of the same bit together
        bus_write(8'h4C, 32'h3, 2'b00);
        bus_write(8'h48, 32'h3, 2'b00);
        bus_write(8'h4C, 32'h3, 2'b01);
        #1 chk("R8 irq held", {31'b0, irq}, 1);
        bus_read(8'h50, d); chk("R8 bit0 kept, bit1 none", d, 32'h1);
        bus_write(8'h4C, 32'h1, 2'b10);
        bus_read(8'h50, d); chk("R8 bit0 cleared, bit1 set", d, 32'h2);

        // R9 clock-source sweep on both timers
        for (int t = 0; t < 2; t++) begin
            for (int c = 0; c < 8; c++) begin
                logic [31:0] w;
                logic [1:0]  other;
                w = 32'hA5A5_0000 | 32'(c) | (32'(t) << 8);
                other = (t == 0) ? clk_src[3:2] : clk_src[1:0];
                bus_write((t == 0) ? 8'h08 : 8'h18, w, 2'b00);
                #1;
                chk("R9 decode", {30'b0, clk_src[2*t +: 2]}, {30'b0, exp_src(c)});
                chk("R9 other timer", {30'b0, (t == 0) ? clk_src[3:2] : clk_src[1:0]}, {30'b0, other});
                bus_read((t == 0) ? 8'h08 : 8'h18, d); chk("R9 ctrl readback", d, w);
            end
        end

        // R10 watchdog write ignored
        bus_write(8'h4C, 32'h3, 2'b00);
        bus_write(8'h48, 32'h1, 2'b00);
        pulse(2'b01);
        begin
            logic [3:0] cs;
            cs = clk_src;
            bus_write(8'h40, 32'hFFFF_FFFF, 2'b00);
            #1;
            chk("R10 irq", {31'b0, irq}, 1);
            chk("R10 clksrc", {28'b0, clk_src}, {28'b0, cs});
        end
        bus_read(8'h48, d); chk("R10 mask", d, 32'h1);
        bus_read(8'h50, d); chk("R10 raw", d, 32'h1);
        bus_read(8'h40, d); chk("R10 wdog read", d, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule